// File: doc/BRIEF.md
# Interrupt Page-Selector Stack

This block holds the register page selector of a small microcontroller together with two saved copies of it, forming a three-deep stack of 8-bit page numbers. The top entry is the page the core uses right now. When the core takes an interrupt, the block replaces the top entry with the page that belongs to the interrupting source, and the older entries each move one place down. When the handler returns, the entries move back up. Nested interrupts therefore leave their pages stacked in the order they arrived, and each return restores the page of the code that was interrupted.

The page for each of the 32 interrupt sources comes from a parameterised lookup table with a per-source valid mask. A source that is not marked valid gets page 0x00. Software may also write any of the three entries directly. An enable input turns the automatic push and pop on or off. A push or pop always overrides a software write issued in the same cycle. If a push and a pop are requested together, the request is treated as a fault and nothing changes.

Top module: `page_stack`

## Requirements
- R1: A synchronous active-high reset sets the current, next and last entries to 0x00.
- R2: With the enable high, a vector strobe alone loads the current entry with the page of the source on the next cycle. The default mapping is: source 2 → 0x02, source 7 → 0x0F, source 11 → 0x00, source 13 → 0x01 and source 20 → 0x03. Every other source gives 0x00.
- R3: On that same push, the old current value moves to the next entry and the old next value moves to the last entry.
- R4: With the enable high, a return strobe alone moves next to current and last to next, and the last entry keeps its value.
- R5: Two nested pushes followed by two returns bring back, in reverse order, the pages that were current before each push.
- R6: When no push or pop takes place, each entry with its write enable high takes its write data on the next cycle. Entries whose write enable is low are unchanged.
- R7: With the enable low, vector and return strobes leave all three entries unchanged, and software writes still apply.
- R8: A software write in the same cycle as a push or pop is ignored. Only the push or pop result appears.
- R9: With the enable high, a vector strobe and a return strobe asserted together leave all three entries unchanged, and any write in that cycle is ignored.
- R10: A value that software wrote into the last entry is lost on the next push, and later returns do not bring it back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| autoEn | input | 1 | Enables automatic push/pop |
| vecStrobe | input | 1 | Interrupt taken (push request) |
| vecSrc | input | 5 | Index of the interrupting source |
| retiStrobe | input | 1 | Return from interrupt (pop request) |
| wrTopEn | input | 1 | Software write enable, current entry |
| wrTopData | input | 8 | Software write data, current entry |
| wrNextEn | input | 1 | Software write enable, next entry |
| wrNextData | input | 8 | Software write data, next entry |
| wrLastEn | input | 1 | Software write enable, last entry |
| wrLastData | input | 8 | Software write data, last entry |
| curPage | output | 8 | Current page (top entry) |
| nextPage | output | 8 | Next entry |
| lastPage | output | 8 | Last entry (bottom) |

## Verification
The assertions are checked on every cycle. They cover the shift pattern of a push and of a pop, the loading of the mapped page, the application of writes, and the hold behaviour when the enable is off, when strobes clash, or when no request is present. Some properties need a sequence of operations and only the bench scenarios can show them. These are the exact page values for mapped and unmapped sources, the restoration of pages after nested interrupts, and the permanent loss of a software-written bottom entry.

// File: rtl/page_stack_pkg.sv
package page_stack_pkg;
  localparam int PAGE_W  = 8;
  localparam int SRC_W   = 5;
  localparam int NUM_SRC = 1 << SRC_W;
  localparam int LEVELS  = 3;

  typedef logic [NUM_SRC*PAGE_W-1:0] mapTable_t;
  typedef logic [NUM_SRC-1:0]        mapValid_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic              push;
    logic              pop;
    logic [LEVELS-1:0] wr;
  } stackCmd_t;

  function automatic mapTable_t defaultMap();
    mapTable_t t;
    t = '0;
    t[2*PAGE_W  +: PAGE_W] = PAGE_W'(8'h02);
    t[7*PAGE_W  +: PAGE_W] = PAGE_W'(8'h0F);
    t[11*PAGE_W +: PAGE_W] = PAGE_W'(8'h00);
    t[13*PAGE_W +: PAGE_W] = PAGE_W'(8'h01);
    t[20*PAGE_W +: PAGE_W] = PAGE_W'(8'h03);
    return t;
  endfunction

  localparam mapValid_t DEFAULT_VALID = mapValid_t'(32'h0010_2884);
endpackage

// File: rtl/page_stack_map.sv
module page_stack_map
  import page_stack_pkg::*;
#(
  parameter mapTable_t MAP_TABLE = defaultMap(),
  parameter mapValid_t MAP_VALID = DEFAULT_VALID
) (
  input  logic [SRC_W-1:0]  src,
  output logic [PAGE_W-1:0] page
);
  always_comb begin
    if (MAP_VALID[src]) page = MAP_TABLE[src*PAGE_W +: PAGE_W];
    else                page = '0;
  end
endmodule

// File: rtl/page_stack_ctrl.sv
module page_stack_ctrl
  import page_stack_pkg::*;
(
  input  logic              autoEn,
  input  logic              vecStrobe,
  input  logic              retiStrobe,
  input  logic [LEVELS-1:0] wrReq,
  output stackCmd_t         cmd
);
  logic eventSeen;

  always_comb begin
    eventSeen = autoEn && (vecStrobe || retiStrobe);
    cmd.push  = autoEn && vecStrobe && !retiStrobe;
    cmd.pop   = autoEn && retiStrobe && !vecStrobe;
    // any enabled event (including a clash) blocks software writes
    cmd.wr    = eventSeen ? '0 : wrReq;
  end
endmodule

// File: rtl/page_stack_dp.sv
module page_stack_dp
  import page_stack_pkg::*;
#(
  parameter int DEPTH = LEVELS,
  parameter int W     = PAGE_W
) (
  input  logic                    clk,
  input  logic                    rst,
  input  stackCmd_t               cmd,
  input  logic [W-1:0]            pushPage,
  input  logic [DEPTH-1:0][W-1:0] wrData,
  output logic [DEPTH-1:0][W-1:0] lvl
);
  for (genvar i = 0; i < DEPTH; i++) begin : g_lvl
    logic [W-1:0] fromAbove;
    logic [W-1:0] fromBelow;

    if (i == 0) begin : g_top
      assign fromAbove = pushPage;
    end else begin : g_mid
      assign fromAbove = lvl[i-1];
    end

    if (i == DEPTH-1) begin : g_bot
      assign fromBelow = lvl[i];
    end else begin : g_up
      assign fromBelow = lvl[i+1];
    end

    always_ff @(posedge clk) begin
      if (rst)             lvl[i] <= '0;
      else if (cmd.push)   lvl[i] <= fromAbove;
      else if (cmd.pop)    lvl[i] <= fromBelow;
      else if (cmd.wr[i])  lvl[i] <= wrData[i];
    end

    // R6
    sw_write_chk: assert property (@(posedge clk) disable iff (rst)
      (cmd.wr[i] && !cmd.push && !cmd.pop) |=> lvl[i] == $past(wrData[i]));
  end

  // R3
  push_shift_chk: assert property (@(posedge clk) disable iff (rst)
    cmd.push |=> (lvl[1] == $past(lvl[0])) && (lvl[2] == $past(lvl[1])));

  // R4
  pop_shift_chk: assert property (@(posedge clk) disable iff (rst)
    cmd.pop |=> (lvl[0] == $past(lvl[1])) && (lvl[1] == $past(lvl[2]))
                && (lvl[2] == $past(lvl[2])));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!cmd.push && !cmd.pop && cmd.wr == '0) |=> $stable(lvl));
endmodule

// File: rtl/page_stack.sv
module page_stack
  import page_stack_pkg::*;
#(
  parameter mapTable_t MAP_TABLE = defaultMap(),
  parameter mapValid_t MAP_VALID = DEFAULT_VALID
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              autoEn,
  input  logic              vecStrobe,
  input  logic [SRC_W-1:0]  vecSrc,
  input  logic              retiStrobe,
  input  logic              wrTopEn,
  input  logic [PAGE_W-1:0] wrTopData,
  input  logic              wrNextEn,
  input  logic [PAGE_W-1:0] wrNextData,
  input  logic              wrLastEn,
  input  logic [PAGE_W-1:0] wrLastData,
  output logic [PAGE_W-1:0] curPage,
  output logic [PAGE_W-1:0] nextPage,
  output logic [PAGE_W-1:0] lastPage
);
  stackCmd_t                     cmd;
  logic [PAGE_W-1:0]             mappedPage;
  logic [LEVELS-1:0][PAGE_W-1:0] wrData;
  logic [LEVELS-1:0][PAGE_W-1:0] lvl;

  assign wrData = {wrLastData, wrNextData, wrTopData};

  page_stack_map #(.MAP_TABLE(MAP_TABLE), .MAP_VALID(MAP_VALID)) u_map (
    .src (vecSrc),
    .page(mappedPage)
  );

  page_stack_ctrl u_ctrl (
    .autoEn    (autoEn),
    .vecStrobe (vecStrobe),
    .retiStrobe(retiStrobe),
    .wrReq     ({wrLastEn, wrNextEn, wrTopEn}),
    .cmd       (cmd)
  );

  page_stack_dp #(.DEPTH(LEVELS), .W(PAGE_W)) u_dp (
    .clk     (clk),
    .rst     (rst),
    .cmd     (cmd),
    .pushPage(mappedPage),
    .wrData  (wrData),
    .lvl     (lvl)
  );

  assign curPage  = lvl[0];
  assign nextPage = lvl[1];
  assign lastPage = lvl[2];

  // R2
  map_load_chk: assert property (@(posedge clk) disable iff (rst)
    (autoEn && vecStrobe && !retiStrobe) |=> curPage == $past(mappedPage));

  // R7
  gate_off_chk: assert property (@(posedge clk) disable iff (rst)
    (!autoEn && !wrTopEn && !wrNextEn && !wrLastEn)
      |=> $stable(curPage) && $stable(nextPage) && $stable(lastPage));

  // R9
  clash_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (autoEn && vecStrobe && retiStrobe)
      |=> $stable(curPage) && $stable(nextPage) && $stable(lastPage));

  // R8
  collide_chk: assert property (@(posedge clk) disable iff (rst)
    (autoEn && vecStrobe && !retiStrobe && wrNextEn) |=> nextPage == $past(curPage));
endmodule

// File: tb/tb_page_stack.sv
module tb_page_stack;
  logic       clk = 1'b0;
  logic       rst;
  logic       autoEn;
  logic       vecStrobe;
  logic [4:0] vecSrc;
  logic       retiStrobe;
  logic       wrTopEn, wrNextEn, wrLastEn;
  logic [7:0] wrTopData, wrNextData, wrLastData;
  logic [7:0] curPage, nextPage, lastPage;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  page_stack dut (
    .clk(clk), .rst(rst), .autoEn(autoEn),
    .vecStrobe(vecStrobe), .vecSrc(vecSrc), .retiStrobe(retiStrobe),
    .wrTopEn(wrTopEn), .wrTopData(wrTopData),
    .wrNextEn(wrNextEn), .wrNextData(wrNextData),
    .wrLastEn(wrLastEn), .wrLastData(wrLastData),
    .curPage(curPage), .nextPage(nextPage), .lastPage(lastPage)
  );

  task automatic idle();
    vecStrobe = 0; retiStrobe = 0; vecSrc = '0;
    wrTopEn = 0; wrNextEn = 0; wrLastEn = 0;
    wrTopData = '0; wrNextData = '0; wrLastData = '0;
  endtask

  task automatic expect3(string req, logic [7:0] c, logic [7:0] n, logic [7:0] l);
    checks++;
    if (curPage !== c || nextPage !== n || lastPage !== l) begin
      errors++;
      $display("FAIL %s: got %02h/%02h/%02h expected %02h/%02h/%02h",
               req, curPage, nextPage, lastPage, c, n, l);
    end
  endtask

  // apply stimulus set up by caller for one edge, then sample
  task automatic tick();
    @(posedge clk); #1;
    idle();
  endtask

  task automatic push(logic [4:0] s);
    @(negedge clk); vecStrobe = 1; vecSrc = s; tick();
  endtask

  task automatic pop();
    @(negedge clk); retiStrobe = 1; tick();
  endtask

  task automatic writeAll(logic [7:0] t, logic [7:0] n, logic [7:0] l);
    @(negedge clk);
    wrTopEn = 1; wrTopData = t; wrNextEn = 1; wrNextData = n;
    wrLastEn = 1; wrLastData = l;
    tick();
  endtask

  task automatic tResetState();
    @(negedge clk); rst = 1; tick(); tick();
    @(negedge clk); rst = 0;
    expect3("R1 initial reset", 8'h00, 8'h00, 8'h00);
  endtask

  task automatic tSoftWrite();
    writeAll(8'h11, 8'h22, 8'h33);
    expect3("R6 write all", 8'h11, 8'h22, 8'h33);
    @(negedge clk); wrNextEn = 1; wrNextData = 8'h44; tick();
    expect3("R6 write next only", 8'h11, 8'h44, 8'h33);
  endtask

  task automatic tPushMap();
    push(5'd2);  expect3("R2 R3 src2", 8'h02, 8'h11, 8'h44);
    push(5'd7);  expect3("R2 R3 src7 old last lost", 8'h0F, 8'h02, 8'h11);
    push(5'd5);  expect3("R2 unmapped src5", 8'h00, 8'h0F, 8'h02);
    push(5'd13); expect3("R2 src13", 8'h01, 8'h00, 8'h0F);
    push(5'd20); expect3("R2 src20", 8'h03, 8'h01, 8'h00);
    push(5'd31); expect3("R2 unmapped src31", 8'h00, 8'h03, 8'h01);
  endtask

  task automatic tPopOrder();
    pop(); expect3("R4 pop 1", 8'h03, 8'h01, 8'h01);
    pop(); expect3("R4 pop 2 last kept", 8'h01, 8'h01, 8'h01);
  endtask

  task automatic tNested();
    writeAll(8'h5A, 8'h00, 8'h00);
    push(5'd2); expect3("R5 first level", 8'h02, 8'h5A, 8'h00);
    push(5'd7); expect3("R5 second level", 8'h0F, 8'h02, 8'h5A);
    pop();      expect3("R5 return inner", 8'h02, 8'h5A, 8'h5A);
    pop();      expect3("R5 return outer", 8'h5A, 8'h5A, 8'h5A);
  endtask

  task automatic tOverflow();
    @(negedge clk); wrLastEn = 1; wrLastData = 8'hC3; tick();
    expect3("R10 last written", 8'h5A, 8'h5A, 8'hC3);
    push(5'd13); expect3("R10 push drops last", 8'h01, 8'h5A, 8'h5A);
    pop(); pop();
    expect3("R10 not recovered", 8'h5A, 8'h5A, 8'h5A);
  endtask

  task automatic tAutoOff();
    @(negedge clk); autoEn = 0;
    @(negedge clk); vecStrobe = 1; vecSrc = 5'd7; tick();
    expect3("R7 vec ignored", 8'h5A, 8'h5A, 8'h5A);
    @(negedge clk); retiStrobe = 1; tick();
    expect3("R7 reti ignored", 8'h5A, 8'h5A, 8'h5A);
    @(negedge clk); vecStrobe = 1; vecSrc = 5'd2; wrTopEn = 1; wrTopData = 8'h77; tick();
    expect3("R7 write applies", 8'h77, 8'h5A, 8'h5A);
    @(negedge clk); autoEn = 1;
  endtask

  task automatic tWriteCollide();
    @(negedge clk); vecStrobe = 1; vecSrc = 5'd2; wrNextEn = 1; wrNextData = 8'hEE; tick();
    expect3("R8 write during push", 8'h02, 8'h77, 8'h5A);
    @(negedge clk); retiStrobe = 1; wrLastEn = 1; wrLastData = 8'hDD;
    wrTopEn = 1; wrTopData = 8'hAA; tick();
    expect3("R8 write during pop", 8'h77, 8'h5A, 8'h5A);
  endtask

  task automatic tClash();
    @(negedge clk); vecStrobe = 1; retiStrobe = 1; vecSrc = 5'd7;
    wrTopEn = 1; wrTopData = 8'h99; tick();
    expect3("R9 clash holds", 8'h77, 8'h5A, 8'h5A);
  endtask

  task automatic tResetMid();
    @(negedge clk); rst = 1; tick();
    @(negedge clk); rst = 0;
    expect3("R1 reset from busy state", 8'h00, 8'h00, 8'h00);
  endtask

  initial begin
    rst = 1; autoEn = 1; idle();
    tResetState();
    tSoftWrite();
    tPushMap();
    tPopOrder();
    tNested();
    tOverflow();
    tAutoOff();
    tWriteCollide();
    tClash();
    tResetMid();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule